// File: doc/BRIEF.md
# Banked GPIO Register Interface

This block is the register front end of a 128-pin general purpose I/O controller. The pins are arranged as four banks of 32. A word-addressed bus with separate read and write strobes, a 12-bit byte offset and 32-bit data reaches per-bank direction, output-latch and alternate-function storage. Dedicated set and clear ports change the output latch without a read-modify-write cycle. Pin number n lives in bank n >> 5 at bit n & 31. The latch and direction registers drive the pads directly as pad data and pad enables.

A pin-level read merges the two sources by direction: driven pins report their latch bit and input pins report the sampled pad level. Each such read also pulses a notify line. Offsets that belong to edge detection (rising enable, falling enable, edge status) are not stored here. They are passed on to a separate edge block through a strobe, bank and kind interface, and that block's read data is returned on the bus. The alternate-function words are only stored and read back.

Accesses are handled by a two-state machine. In `ST_IDLE` no response is presented. Any strobe causes the ACCEPT transition to `ST_RESP`. In `ST_RESP` the captured response (read data, valid, error, notify) is shown for one cycle. Another strobe takes the CHAIN transition and stays in `ST_RESP`; otherwise the RETIRE transition returns to `ST_IDLE`. Register writes take effect at the edge that samples the write strobe.

Top module: `gpio_bank_regif`

## Requirements
- R1: Pin n maps to bank n >> 5 and bit n & 31, so bit k of bank b drives `pad_out[32*b+k]` and `pad_oe[32*b+k]`.
- R2: For banks 0, 1 and 2, pin-level, direction, set and clear sit at base + 4*b, with bases 0x000, 0x00C, 0x018 and 0x024. Bank 3 of each sits at base + 0x100. Direction reads back as written.
- R3: A write to the set port ORs the data into the bank's output latch. A write to the clear port ANDs the latch with the inverted data.
- R4: A pin-level read returns (latch AND direction) OR (`pad_in` AND NOT direction), with direction 1 meaning output.
- R5: Reading a set port returns the last value written to that port. Reading a clear port returns 0x00007A69.
- R6: The alternate-function low word of bank b is at 0x054 + 8*b and the high word is at 0x058 + 8*b. Both read back as written and have no effect on `pad_out` or `pad_oe`.
- R7: Edge offsets use bases 0x030 (kind 0, rising enable), 0x03C (kind 1, falling enable) and 0x048 (kind 2, status), with the same bank layout as R2. An access to one of them raises `edge_rd` or `edge_wr` in the strobe cycle, with `edge_bank` = b, `edge_kind` = the kind code and `edge_wdata` = bus data. A read returns `edge_rdata`.
- R8: Offsets 0x200 and above read as zero with no error and are ignored on write.
- R9: An offset below 0x200 that matches no register, including any offset not a multiple of 4, reads as zero, raises `bus_err` for one cycle and changes no state when written.
- R10: `lvl_read_pulse` is high for one cycle after a pin-level read and after no other access.
- R11: After reset, direction, latch, alternate-function and set-shadow registers are zero, and so are `pad_out` and `pad_oe`.
- R12: The response to a strobe at clock edge k (`bus_rvalid` for reads, `bus_rdata`, `bus_err`, `lvl_read_pulse`) is visible for exactly the cycle after edge k.
- R13: `pad_out` and `pad_oe` are register outputs and change at the edge that samples the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 12 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read response valid |
| bus_err | output | 1 | Unmapped offset access |
| lvl_read_pulse | output | 1 | Pin-level read notification |
| pad_in | input | 128 | Sampled pad input levels |
| pad_out | output | 128 | Pad output data |
| pad_oe | output | 128 | Pad output enable |
| edge_rd | output | 1 | Read forwarded to the edge block |
| edge_wr | output | 1 | Write forwarded to the edge block |
| edge_bank | output | 2 | Bank of the forwarded access |
| edge_kind | output | 2 | 0 rising enable, 1 falling enable, 2 status |
| edge_wdata | output | 32 | Forwarded write data |
| edge_rdata | input | 32 | Read data from the edge block |

## Verification
The assertions assume that `bus_rd` and `bus_wr` are never high in the same cycle, that `pad_in` is already synchronous to `clk`, and that `edge_rdata` settles combinationally from `edge_bank` and `edge_kind` within the strobe cycle. The bench keeps to this. It drives exactly one strobe per access, changes inputs only at the falling edge, and returns edge data computed from the forwarded bank and kind alone. Near-exhaustive sweeps cover every offset below 0x200, all 128 pins one at a time, and every bank for every register kind.

// File: rtl/gpio_rif_pkg.sv
package gpio_rif_pkg;

    localparam int NBANK      = 4;
    localparam int BANK_IDX_W = $clog2(NBANK);
    localparam int ADDR_W     = 12;

    localparam logic [ADDR_W-1:0] RANGE_LIMIT   = 12'h200;
    localparam logic [ADDR_W-1:0] HIGH_BANK_OFS = 12'h100;
    localparam int                FAMILY_STRIDE = 12;
    localparam logic [ADDR_W-1:0] AF_LO_BASE    = 12'h054;
    localparam logic [ADDR_W-1:0] AF_HI_BASE    = 12'h058;
    localparam logic [31:0]       CLR_READ_WORD = 32'h0000_7A69;

    // Family order matters: index k has base FAMILY_STRIDE*k
    typedef enum logic [3:0] {
        K_NONE = 4'd0,
        K_LVL  = 4'd1,
        K_DIR  = 4'd2,
        K_SET  = 4'd3,
        K_CLR  = 4'd4,
        K_RISE = 4'd5,
        K_FALL = 4'd6,
        K_STAT = 4'd7,
        K_AFLO = 4'd8,
        K_AFHI = 4'd9,
        K_OOR  = 4'd10
    } reg_kind_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } acc_state_e;

    typedef struct packed {
        reg_kind_e              kind;
        logic [BANK_IDX_W-1:0]  bank;
    } dec_t;

    // Offset of bank b within a register family
    function automatic logic [ADDR_W-1:0] family_offset(input int fam, input int b);
        logic [ADDR_W-1:0] base;
        base = ADDR_W'(FAMILY_STRIDE * fam);
        if (b == NBANK - 1)
            return base + HIGH_BANK_OFS;
        return base + ADDR_W'(4 * b);
    endfunction

    function automatic dec_t decode_offset(input logic [ADDR_W-1:0] ofs);
        dec_t r;
        r.kind = K_NONE;
        r.bank = '0;
        if (ofs >= RANGE_LIMIT) begin
            r.kind = K_OOR;
        end else begin
            for (int fam = 0; fam < 7; fam++) begin
                for (int b = 0; b < NBANK; b++) begin
                    if (ofs == family_offset(fam, b)) begin
                        r.kind = reg_kind_e'(4'(fam + 1));
                        r.bank = BANK_IDX_W'(b);
                    end
                end
            end
            for (int b = 0; b < NBANK; b++) begin
                if (ofs == AF_LO_BASE + ADDR_W'(8 * b)) begin
                    r.kind = K_AFLO;
                    r.bank = BANK_IDX_W'(b);
                end
                if (ofs == AF_HI_BASE + ADDR_W'(8 * b)) begin
                    r.kind = K_AFHI;
                    r.bank = BANK_IDX_W'(b);
                end
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/gpio_rif_decode.sv
module gpio_rif_decode
    import gpio_rif_pkg::*;
(
    input  logic [ADDR_W-1:0]      ofs,
    output reg_kind_e              kind,
    output logic [BANK_IDX_W-1:0]  bank,
    output logic [NBANK-1:0]       bank_sel,
    output logic                   edge_hit,
    output logic [1:0]             edge_code
);
    dec_t dec;

    always_comb begin
        dec  = decode_offset(ofs);
        kind = dec.kind;
        bank = dec.bank;
    end

    // One select per bank for the locally stored families
    for (genvar g = 0; g < NBANK; g++) begin : g_sel
        assign bank_sel[g] = (bank == BANK_IDX_W'(g)) &&
                             (kind inside {K_LVL, K_DIR, K_SET, K_CLR, K_AFLO, K_AFHI});
    end

    always_comb begin
        edge_hit  = 1'b0;
        edge_code = 2'd0;
        unique case (kind)
            K_RISE: begin edge_hit = 1'b1; edge_code = 2'd0; end
            K_FALL: begin edge_hit = 1'b1; edge_code = 2'd1; end
            K_STAT: begin edge_hit = 1'b1; edge_code = 2'd2; end
            default: begin edge_hit = 1'b0; edge_code = 2'd0; end
        endcase
    end

    always_comb begin
        AST_SEL_ONEHOT: assert ($onehot0(bank_sel) && !(edge_hit && |bank_sel)); // R2
    end

endmodule

// File: rtl/gpio_rif_bank.sv
module gpio_rif_bank #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         dir_we,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic         aflo_we,
    input  logic         afhi_we,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] lat_q,
    output logic [W-1:0] aflo_q,
    output logic [W-1:0] afhi_q,
    output logic [W-1:0] shadow_q,
    output logic [W-1:0] level
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q    <= '0;
            lat_q    <= '0;
            aflo_q   <= '0;
            afhi_q   <= '0;
            shadow_q <= '0;
        end else begin
            if (dir_we)  dir_q  <= wdata;
            if (aflo_we) aflo_q <= wdata;
            if (afhi_we) afhi_q <= wdata;
            if (set_we) begin
                lat_q    <= lat_q | wdata;
                shadow_q <= wdata;
            end else if (clr_we) begin
                lat_q    <= lat_q & ~wdata;
            end
        end
    end

    // Per-pin merge of driven and sampled levels
    assign level = (lat_q & dir_q) | (pin_in & ~dir_q);

    AST_SET_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        set_we |=> ((lat_q & $past(wdata)) == $past(wdata))); // R3
    AST_CLR_ZEROS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((lat_q & $past(wdata)) == '0)); // R3
    AST_LAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_we && !clr_we) |=> $stable(lat_q)); // R13
    AST_AF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!aflo_we && !afhi_we) |=> ($stable(aflo_q) && $stable(afhi_q))); // R6

endmodule

// File: rtl/gpio_rif_ctrl.sv
module gpio_rif_ctrl
    import gpio_rif_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd,
    input  logic          wr,
    input  reg_kind_e     kind,
    input  logic [DW-1:0] rmux,
    output logic [DW-1:0] rdata,
    output logic          rvalid,
    output logic          err,
    output logic          notify
);
    acc_state_e    state_q, state_d;
    logic          held_rd, held_err, held_note;
    logic [DW-1:0] held_data;
    logic          strobe;

    assign strobe = rd | wr;

    // Transitions: ACCEPT (IDLE->RESP), CHAIN (RESP->RESP), RETIRE (RESP->IDLE)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = strobe ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = strobe ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            held_rd   <= 1'b0;
            held_err  <= 1'b0;
            held_note <= 1'b0;
            held_data <= '0;
        end else begin
            state_q <= state_d;
            if (strobe) begin
                held_rd   <= rd;
                held_err  <= (kind == K_NONE);
                held_note <= rd && (kind == K_LVL);
                held_data <= rd ? rmux : '0;
            end
        end
    end

    always_comb begin
        rdata  = '0;
        rvalid = 1'b0;
        err    = 1'b0;
        notify = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RESP: begin
                rvalid = held_rd;
                rdata  = held_rd ? held_data : '0;
                err    = held_err;
                notify = held_note;
            end
            default: ;
        endcase
    end

    AST_RVALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> rvalid); // R12
    AST_WRITE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> !rvalid); // R12
    AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (err && rvalid) |-> (rdata == '0)); // R9
    AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> !err); // R9
    AST_NOTIFY_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        notify |-> (rvalid && !err)); // R10

endmodule

// File: rtl/gpio_bank_regif.sv
module gpio_bank_regif
    import gpio_rif_pkg::*;
#(
    parameter int BANK_W = 32,
    localparam int NPIN  = NBANK * BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BANK_W-1:0] bus_wdata,
    output logic [BANK_W-1:0] bus_rdata,
    output logic              bus_rvalid,
    output logic              bus_err,
    output logic              lvl_read_pulse,
    input  logic [NPIN-1:0]   pad_in,
    output logic [NPIN-1:0]   pad_out,
    output logic [NPIN-1:0]   pad_oe,
    output logic              edge_rd,
    output logic              edge_wr,
    output logic [BANK_IDX_W-1:0] edge_bank,
    output logic [1:0]        edge_kind,
    output logic [BANK_W-1:0] edge_wdata,
    input  logic [BANK_W-1:0] edge_rdata
);
    reg_kind_e             kind;
    logic [BANK_IDX_W-1:0] bank;
    logic [NBANK-1:0]      bank_sel;
    logic                  edge_hit;
    logic [1:0]            edge_code;
    logic [BANK_W-1:0]     rmux;

    logic [BANK_W-1:0] dir_a    [NBANK];
    logic [BANK_W-1:0] lat_a    [NBANK];
    logic [BANK_W-1:0] aflo_a   [NBANK];
    logic [BANK_W-1:0] afhi_a   [NBANK];
    logic [BANK_W-1:0] shadow_a [NBANK];
    logic [BANK_W-1:0] level_a  [NBANK];

    gpio_rif_decode u_dec (
        .ofs       (bus_addr),
        .kind      (kind),
        .bank      (bank),
        .bank_sel  (bank_sel),
        .edge_hit  (edge_hit),
        .edge_code (edge_code)
    );

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        gpio_rif_bank #(.W(BANK_W)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .dir_we   (bus_wr && bank_sel[g] && (kind == K_DIR)),
            .set_we   (bus_wr && bank_sel[g] && (kind == K_SET)),
            .clr_we   (bus_wr && bank_sel[g] && (kind == K_CLR)),
            .aflo_we  (bus_wr && bank_sel[g] && (kind == K_AFLO)),
            .afhi_we  (bus_wr && bank_sel[g] && (kind == K_AFHI)),
            .wdata    (bus_wdata),
            .pin_in   (pad_in[g*BANK_W +: BANK_W]),
            .dir_q    (dir_a[g]),
            .lat_q    (lat_a[g]),
            .aflo_q   (aflo_a[g]),
            .afhi_q   (afhi_a[g]),
            .shadow_q (shadow_a[g]),
            .level    (level_a[g])
        );
        assign pad_out[g*BANK_W +: BANK_W] = lat_a[g];
        assign pad_oe[g*BANK_W +: BANK_W]  = dir_a[g];
    end

    assign edge_rd    = bus_rd && edge_hit;
    assign edge_wr    = bus_wr && edge_hit;
    assign edge_bank  = bank;
    assign edge_kind  = edge_code;
    assign edge_wdata = bus_wdata;

    always_comb begin
        rmux = '0;
        unique case (kind)
            K_LVL:  rmux = level_a[bank];
            K_DIR:  rmux = dir_a[bank];
            K_SET:  rmux = shadow_a[bank];
            K_CLR:  rmux = BANK_W'(CLR_READ_WORD);
            K_RISE, K_FALL, K_STAT: rmux = edge_rdata;
            K_AFLO: rmux = aflo_a[bank];
            K_AFHI: rmux = afhi_a[bank];
            default: rmux = '0;
        endcase
    end

    gpio_rif_ctrl #(.DW(BANK_W)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd     (bus_rd),
        .wr     (bus_wr),
        .kind   (kind),
        .rmux   (rmux),
        .rdata  (bus_rdata),
        .rvalid (bus_rvalid),
        .err    (bus_err),
        .notify (lvl_read_pulse)
    );

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr)); // R12
    AST_OOR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr >= RANGE_LIMIT)) |=> ($stable(pad_out) && $stable(pad_oe))); // R8
    AST_OOR_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_rd || bus_wr) && (bus_addr >= RANGE_LIMIT)) |=> (!bus_err && (bus_rdata == '0))); // R8
    AST_EDGE_NO_PAD: assert property (@(posedge clk) disable iff (!rst_n)
        edge_wr |=> ($stable(pad_out) && $stable(pad_oe))); // R7

endmodule

// File: tb/sim_gpio_bank_regif.sv
module sim_gpio_bank_regif;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_rd = 1'b0, bus_wr = 1'b0;
    logic [11:0]  bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic         bus_rvalid, bus_err, lvl_read_pulse;
    logic [127:0] pad_in = '0;
    logic [127:0] pad_out, pad_oe;
    logic         edge_rd, edge_wr;
    logic [1:0]   edge_bank, edge_kind;
    logic [31:0]  edge_wdata, edge_rdata;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    assign edge_rdata = 32'hED00_0000 | (32'(edge_kind) << 4) | 32'(edge_bank);

    gpio_bank_regif u0 (.*);

    logic [31:0] r_data;
    logic r_v, r_e, r_n;
    logic s_erd, s_ewr;
    logic [1:0] s_ebank, s_ekind;
    logic [31:0] s_ewdata;
    logic [31:0] mdir [4];
    logic [31:0] mlat [4];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic [11:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = wr;
        bus_rd    = !wr;
        #1;
        s_erd = edge_rd; s_ewr = edge_wr; s_ebank = edge_bank;
        s_ekind = edge_kind; s_ewdata = edge_wdata;
        @(posedge clk);
        @(negedge clk);
        r_data = bus_rdata; r_v = bus_rvalid; r_e = bus_err; r_n = lvl_read_pulse;
        bus_rd = 1'b0;
        bus_wr = 1'b0;
    endtask

    function automatic logic [11:0] fam_off(input int fam, input int b);
        return (b == 3) ? 12'(12 * fam + 'h100) : 12'(12 * fam + 4 * b);
    endfunction

    function automatic bit is_mapped(input int o);
        for (int f = 0; f < 7; f++)
            for (int b = 0; b < 4; b++)
                if (o == int'(fam_off(f, b))) return 1'b1;
        for (int b = 0; b < 4; b++)
            if (o == 'h54 + 8 * b || o == 'h58 + 8 * b) return 1'b1;
        return 1'b0;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL R12 watchdog actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [127:0] po, pe;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        chk(pad_out == '0 && pad_oe == '0, "R11", "pads after reset", {pad_out[63:0], pad_oe[63:0]}, '0);
        chk(!bus_rvalid && !bus_err && !lvl_read_pulse, "R12", "idle outputs", {bus_rvalid, bus_err, lvl_read_pulse}, '0);
        for (int b = 0; b < 4; b++) begin
            access(1'b0, fam_off(1, b), '0);
            chk(r_data == '0 && r_v, "R11", "dir reset", r_data, '0);
            access(1'b0, fam_off(2, b), '0);
            chk(r_data == '0, "R11", "set shadow reset", r_data, '0);
            access(1'b0, 12'(8'h54 + 8 * b), '0);
            chk(r_data == '0, "R11", "af low reset", r_data, '0);
            mdir[b] = '0; mlat[b] = '0;
        end

        // R1 walk every pin through the set and clear ports
        for (int p = 0; p < 128; p++) begin
            access(1'b1, fam_off(2, p >> 5), 32'(1) << (p & 31));
            chk(pad_out == (128'(1) << p), "R1", $sformatf("pin %0d set", p), pad_out, 128'(1) << p);
            access(1'b1, fam_off(3, p >> 5), 32'(1) << (p & 31));
            chk(pad_out == '0, "R1", $sformatf("pin %0d clear", p), pad_out, '0);
        end

        // R2 R3 R4 R13 patterns in every bank
        for (int rnd = 0; rnd < 3; rnd++) begin
            pad_in = {32'h1357_9BDF ^ 32'(rnd * 'h0F0F), 32'hA5A5_5A5A + 32'(rnd),
                      32'hFFFF_0000 >> rnd, 32'h0123_4567 << rnd};
            for (int b = 0; b < 4; b++) begin
                logic [31:0] d, s, c, lv;
                d = 32'hF0F0_3C3C ^ (32'(b + rnd) * 32'h1111_1111);
                s = 32'h0FF0_8421 + 32'(b * 7 + rnd);
                c = 32'h0300_8001 << (b + rnd);
                access(1'b1, fam_off(1, b), d);
                mdir[b] = d;
                chk(pad_oe[32*b +: 32] == d, "R13", "pad_oe after dir write", pad_oe[32*b +: 32], d);
                access(1'b1, fam_off(2, b), s);
                mlat[b] = mlat[b] | s;
                chk(pad_out[32*b +: 32] == mlat[b], "R3", "latch after set", pad_out[32*b +: 32], mlat[b]);
                access(1'b1, fam_off(3, b), c);
                mlat[b] = mlat[b] & ~c;
                chk(pad_out[32*b +: 32] == mlat[b], "R3", "latch after clear", pad_out[32*b +: 32], mlat[b]);
                access(1'b0, fam_off(1, b), '0);
                chk(r_data == d && r_v, "R2", "dir readback", r_data, d);
                lv = (mlat[b] & mdir[b]) | (pad_in[32*b +: 32] & ~mdir[b]);
                access(1'b0, fam_off(0, b), '0);
                chk(r_data == lv, "R4", "level merge", r_data, lv);
                chk(r_n && r_v && !r_e, "R10", "notify on level read", {r_n, r_v, r_e}, 3'b110);
            end
            for (int b = 0; b < 4; b++)
                chk(pad_out[32*b +: 32] == mlat[b] && pad_oe[32*b +: 32] == mdir[b], "R1",
                    "bank isolation", pad_out[32*b +: 32], mlat[b]);
        end

        // R5 set shadow and clear constant
        for (int b = 0; b < 4; b++) begin
            logic [31:0] v;
            v = 32'hC0FF_EE00 | 32'(b);
            access(1'b1, fam_off(2, b), v);
            mlat[b] = mlat[b] | v;
            access(1'b1, fam_off(3, b), 32'h0000_00F0);
            mlat[b] = mlat[b] & ~32'h0000_00F0;
            access(1'b0, fam_off(2, b), '0);
            chk(r_data == v, "R5", "set readback", r_data, v);
            access(1'b0, fam_off(3, b), '0);
            chk(r_data == 32'h0000_7A69, "R5", "clear readback", r_data, 32'h0000_7A69);
            chk(!r_n, "R10", "no notify on clear read", r_n, 1'b0);
        end

        // R6 alternate function words
        po = pad_out; pe = pad_oe;
        for (int b = 0; b < 4; b++) begin
            access(1'b1, 12'('h54 + 8 * b), 32'hA1A0_0000 + 32'(b));
            access(1'b1, 12'('h58 + 8 * b), 32'hB1B0_0000 + 32'(b));
        end
        chk(pad_out == po && pad_oe == pe, "R6", "af writes leave pads", pad_out, po);
        for (int b = 0; b < 4; b++) begin
            access(1'b0, 12'('h54 + 8 * b), '0);
            chk(r_data == 32'hA1A0_0000 + 32'(b), "R6", "af low readback", r_data, 32'hA1A0_0000 + 32'(b));
            access(1'b0, 12'('h58 + 8 * b), '0);
            chk(r_data == 32'hB1B0_0000 + 32'(b), "R6", "af high readback", r_data, 32'hB1B0_0000 + 32'(b));
        end

        // R7 edge forwarding
        for (int k = 0; k < 3; k++) begin
            for (int b = 0; b < 4; b++) begin
                logic [31:0] ex;
                ex = 32'hED00_0000 | 32'(k << 4) | 32'(b);
                access(1'b0, fam_off(4 + k, b), '0);
                chk(s_erd && !s_ewr && s_ebank == 2'(b) && s_ekind == 2'(k), "R7", "edge read strobe",
                    {s_erd, s_ewr, s_ebank, s_ekind}, {1'b1, 1'b0, 2'(b), 2'(k)});
                chk(r_data == ex && r_v && !r_e, "R7", "edge read data", r_data, ex);
                access(1'b1, fam_off(4 + k, b), 32'h5EED_0000 + 32'(k * 4 + b));
                chk(s_ewr && !s_erd && s_ewdata == 32'h5EED_0000 + 32'(k * 4 + b), "R7", "edge write strobe",
                    s_ewdata, 32'h5EED_0000 + 32'(k * 4 + b));
            end
        end
        chk(pad_out == po && pad_oe == pe, "R7", "edge writes leave pads", pad_out, po);

        // R8 out of range
        access(1'b1, 12'h200, 32'hFFFF_FFFF);
        chk(!r_e && pad_out == po && pad_oe == pe, "R8", "oor write ignored", pad_oe, pe);
        access(1'b1, 12'h30C, 32'hFFFF_FFFF);
        chk(pad_out == po && pad_oe == pe, "R8", "oor alias write ignored", pad_oe, pe);
        access(1'b0, 12'h300, '0);
        chk(r_data == '0 && r_v && !r_e && !r_n, "R8", "oor read", r_data, '0);
        access(1'b0, 12'hFFC, '0);
        chk(r_data == '0 && !r_e, "R8", "top oor read", r_data, '0);

        // R9 R10 sweep of every offset below the range limit
        for (int o = 0; o < 'h200; o++) begin
            bit m, lvl;
            m = ((o & 3) == 0) && is_mapped(o);
            lvl = (o == 0 || o == 4 || o == 8 || o == 'h100);
            access(1'b0, 12'(o), '0);
            if (!m)
                chk(r_e && r_v && r_data == '0 && !r_n, "R9", $sformatf("unmapped %0h", o),
                    {r_e, r_v, r_n, r_data}, {3'b110, 32'h0});
            else
                chk(!r_e && r_v && r_n == lvl, "R10", $sformatf("mapped %0h", o),
                    {r_e, r_v, r_n}, {2'b01, lvl});
        end

        // R9 writes to unmapped offsets change nothing
        access(1'b1, 12'h074, 32'hFFFF_FFFF);
        chk(r_e && !r_v, "R9", "unmapped write err", {r_e, r_v}, 2'b10);
        access(1'b1, 12'h00D, 32'hFFFF_FFFF);
        access(1'b1, 12'h1FC, 32'hFFFF_FFFF);
        access(1'b1, 12'h0FC, 32'hFFFF_FFFF);
        chk(pad_out == po && pad_oe == pe, "R9", "unmapped writes leave pads", pad_out, po);
        access(1'b0, 12'h054, '0);
        chk(r_data == 32'hA1A0_0000 && !r_e, "R9", "af intact", r_data, 32'hA1A0_0000);
        @(negedge clk);
        chk(!bus_err && !bus_rvalid, "R12", "response lasts one cycle", {bus_err, bus_rvalid}, 2'b00);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule